// File: doc/BRIEF.md
# PCM Time-Slot Capture Buffer

This block takes in a serial PCM highway and turns it into parallel bytes. The highway carries 256 time slots per frame, each slot one 8-bit sample of a 64 kbit/s channel. Bits arrive most significant first, one per enabled clock. A frame-sync strobe marks bit 0 of slot 0. The bytes go into a 2048-byte ring that holds eight frames. The ring is split into two halves of four frames each.

Storage is ordered by channel, not by arrival. Inside a half, one slot's four samples from four consecutive frames sit side by side, so one 32-bit read returns four successive samples of a single channel. The read address is {half, slot}, and byte lane n of the word (bits 8n+7..8n) holds frame n of that half.

When the last byte of a half has been written, the block gives a one-cycle ready pulse with the index of that half. A processor can then drain that half while the other half fills. A sync that arrives before a full frame of bits forces the bit and slot position back to zero and sets a sticky framing-error flag.

Top module: `pcm_slot_capture`

## Requirements
- R1: After reset, halfReady and frameErr are 0 and rdData is all zeros.
- R2: Bits presented before the first frameSync (with bitEn high) are not captured, and no ready pulse is produced before that sync.
- R3: Each byte is assembled most significant bit first: the first bit of a slot after the frame start becomes bit 7 of the stored sample.
- R4: Frame f of the ring (0..7) belongs to half f/4. The sample of slot s in frame f is returned by a read of row {f/4, s}, in byte lane f%4, at bits 8*(f%4)+7 .. 8*(f%4).
- R5: halfReady is high for exactly one cycle. That is the cycle after the clock edge that samples the last bit of the last slot of the fourth frame of a half, and halfIdx then gives that half (0 or 1).
- R6: After the eighth frame the ring wraps to frame 0. New data overwrite half 0 while half 1 keeps its contents, and successive ready pulses alternate between the two halves.
- R7: Once synchronised the block free-runs with no further sync. A sync that arrives exactly on a frame boundary does not set frameErr.
- R8: A sync that arrives early resets the bit and slot position to zero. Early means while the bit or slot position is not zero. The partial frame is overwritten in the same ring frame, and frameErr is set and stays 1 until reset.
- R9: rdData shows the word at rdAddr one clock edge after the address is applied.
- R10: While bitEn is low, serIn and frameSync are ignored. Capture resumes at the same bit position when bitEn returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Qualifies serIn and frameSync for this cycle |
| serIn | input | 1 | Serial PCM data, most significant bit first |
| frameSync | input | 1 | Marks bit 0 of slot 0 when bitEn is high |
| rdAddr | input | SLOT_W+1 | Read row {half, slot} |
| rdData | output | 4*8 | Four samples of one slot, lane n = frame n of the half |
| halfReady | output | 1 | One-cycle pulse: a half of the ring is complete |
| halfIdx | output | 1 | Index of the half just completed |
| frameErr | output | 1 | Sticky flag: an early frame sync was seen |

## Verification
A wrong bit or slot position would be visible within one frame. The ready pulse would move off the predicted bit, and the words read back would have rotated or merged bytes. A wrong frame counter would show at the next read of a half: lanes out of place, or the wrong half overwritten on the wrap. A lost or misapplied resynchronisation would show as a missing frameErr, or as stale samples in lane 0 of the resynchronised half once that half reports ready. The small sweep checks every slot and every lane of both halves across a full ring, the wrap, and an early sync, and it tests the ready timing on every sampled bit.

// File: rtl/pcm_capture_pkg.sv
package pcm_capture_pkg;
  typedef struct packed {
    logic shiftEn;  // accept one serial bit into the assembler
    logic wrEn;     // completed sample must be written this edge
  } capStrobe_t;
endpackage

// File: rtl/pcm_lane_ram.sv
module pcm_lane_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/pcm_capture_ctrl.sv
module pcm_capture_ctrl
  import pcm_capture_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int BIT_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  output capStrobe_t        strobe,
  output logic [LANE_W-1:0] wrLane,
  output logic [SLOT_W:0]   wrRow,
  output logic              halfReady,
  output logic              halfIdx,
  output logic              frameErr
);
  localparam int FRAME_W = LANE_W + 1;

  logic [BIT_W-1:0]   bitCnt;
  logic [SLOT_W-1:0]  slotCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic               locked;

  logic               syncSeen, early, active;
  logic [BIT_W-1:0]   curBit;
  logic [SLOT_W-1:0]  curSlot;
  logic               lastBit, lastSlot, frameEnd, halfEnd;

  always_comb begin
    syncSeen = bitEn & frameSync;
    early    = syncSeen & locked & ((bitCnt != '0) | (slotCnt != '0));
    curBit   = syncSeen ? '0 : bitCnt;
    curSlot  = syncSeen ? '0 : slotCnt;
    active   = bitEn & (locked | frameSync);
    lastBit  = (curBit == '1);
    lastSlot = (curSlot == '1);

    strobe.shiftEn = bitEn;
    strobe.wrEn    = active & lastBit;
    frameEnd       = strobe.wrEn & lastSlot;
    halfEnd        = frameEnd & (frameCnt[LANE_W-1:0] == '1);

    wrLane = frameCnt[LANE_W-1:0];
    wrRow  = {frameCnt[LANE_W], curSlot};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      slotCnt   <= '0;
      frameCnt  <= '0;
      locked    <= 1'b0;
      frameErr  <= 1'b0;
      halfReady <= 1'b0;
      halfIdx   <= 1'b0;
    end else begin
      halfReady <= halfEnd;
      if (halfEnd) halfIdx <= frameCnt[LANE_W];
      if (syncSeen) locked <= 1'b1;
      if (early) frameErr <= 1'b1;
      if (active) begin
        bitCnt  <= curBit + 1'b1;
        slotCnt <= lastBit ? curSlot + 1'b1 : curSlot;
        if (frameEnd) frameCnt <= frameCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_capture_dp.sv
module pcm_capture_dp
  import pcm_capture_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int BIT_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              serIn,
  input  capStrobe_t                        strobe,
  input  logic [LANE_W-1:0]                 wrLane,
  input  logic [SLOT_W:0]                   wrRow,
  input  logic [SLOT_W:0]                   rdAddr,
  output logic [(1<<LANE_W)*(1<<BIT_W)-1:0] rdData
);
  localparam int SAMPLE_W = 1 << BIT_W;
  localparam int LANES    = 1 << LANE_W;
  localparam int ROW_W    = SLOT_W + 1;

  logic [SAMPLE_W-2:0] shiftReg;
  logic [SAMPLE_W-1:0] nextSample;

  assign nextSample = {shiftReg, serIn};

  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= nextSample[SAMPLE_W-2:0];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic laneWe;
    assign laneWe = strobe.wrEn && (wrLane == LANE_W'(g));
    pcm_lane_ram #(.ADDR_W(ROW_W), .DATA_W(SAMPLE_W)) u_ram (
      .clk    (clk),
      .rstN   (rstN),
      .we     (laneWe),
      .wrAddr (wrRow),
      .wrData (nextSample),
      .rdAddr (rdAddr),
      .rdData (rdData[g*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/pcm_slot_capture.sv
module pcm_slot_capture
  import pcm_capture_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int BIT_W  = 3,
  parameter int LANE_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              bitEn,
  input  logic                              serIn,
  input  logic                              frameSync,
  input  logic [SLOT_W:0]                   rdAddr,
  output logic [(1<<LANE_W)*(1<<BIT_W)-1:0] rdData,
  output logic                              halfReady,
  output logic                              halfIdx,
  output logic                              frameErr
);
  capStrobe_t        strobe;
  logic [LANE_W-1:0] wrLane;
  logic [SLOT_W:0]   wrRow;

  pcm_capture_ctrl #(.SLOT_W(SLOT_W), .BIT_W(BIT_W), .LANE_W(LANE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .frameSync (frameSync),
    .strobe    (strobe),
    .wrLane    (wrLane),
    .wrRow     (wrRow),
    .halfReady (halfReady),
    .halfIdx   (halfIdx),
    .frameErr  (frameErr)
  );

  pcm_capture_dp #(.SLOT_W(SLOT_W), .BIT_W(BIT_W), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .serIn  (serIn),
    .strobe (strobe),
    .wrLane (wrLane),
    .wrRow  (wrRow),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: rtl/pcm_capture_checker.sv
module pcm_capture_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic frameSync,
  input logic halfReady,
  input logic halfIdx,
  input logic frameErr
);
  logic seenSync;
  logic lastValid;
  logic lastHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenSync  <= 1'b0;
      lastValid <= 1'b0;
      lastHalf  <= 1'b0;
    end else begin
      if (bitEn && frameSync) seenSync <= 1'b1;
      if (halfReady) begin
        lastValid <= 1'b1;
        lastHalf  <= halfIdx;
      end
    end
  end

  p_quiet_before_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    !seenSync |-> !halfReady);

  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    halfReady |=> !halfReady);

  p_ready_after_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfReady) |-> $past(bitEn));

  p_half_alternate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halfReady && lastValid) |-> (halfIdx != lastHalf));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(bitEn && frameSync));
endmodule

bind pcm_slot_capture pcm_capture_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .frameSync (frameSync),
  .halfReady (halfReady),
  .halfIdx   (halfIdx),
  .frameErr  (frameErr)
);

// File: tb/pcm_slot_capture_test.sv
module pcm_slot_capture_test;
  localparam int SLOT_W = 3;
  localparam int SLOTS  = 1 << SLOT_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        serIn = 1'b0;
  logic        frameSync = 1'b0;
  logic [SLOT_W:0] rdAddr = '0;
  logic [31:0] rdData;
  logic        halfReady, halfIdx, frameErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pcm_slot_capture #(.SLOT_W(SLOT_W), .BIT_W(3), .LANE_W(2)) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .serIn(serIn), .frameSync(frameSync),
    .rdAddr(rdAddr), .rdData(rdData), .halfReady(halfReady), .halfIdx(halfIdx),
    .frameErr(frameErr)
  );

  function automatic logic [7:0] sampleOf(int pass, int frame, int slot);
    return 8'((pass * 97 + frame * 29 + slot * 13 + 5) & 8'hFF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleCycle();
    @(negedge clk);
    bitEn = 1'b0; serIn = 1'b1; frameSync = 1'b1;  // must be ignored (R10)
    @(posedge clk); #1;
    check("R10 ready quiet while bitEn low", {31'b0, halfReady}, 32'd0);
  endtask

  task automatic sendBit(logic b, logic s, logic expR, logic expH);
    @(negedge clk);
    bitEn = 1'b1; serIn = b; frameSync = s;
    @(posedge clk); #1;
    check("R5 ready timing", {31'b0, halfReady}, {31'b0, expR});
    if (expR) check("R5 ready half index", {31'b0, halfIdx}, {31'b0, expH});
  endtask

  task automatic sendFrame(int pass, int ringFrame, bit sync, bit gaps);
    for (int s = 0; s < SLOTS; s++) begin
      logic [7:0] v;
      v = sampleOf(pass, ringFrame, s);
      for (int b = 0; b < 8; b++) begin
        if (gaps && b == 3) idleCycle();
        sendBit(v[7-b], sync && s == 0 && b == 0,
                (s == SLOTS-1) && (b == 7) && (ringFrame % 4 == 3),
                1'(ringFrame / 4));
      end
    end
  endtask

  task automatic readRow(int half, int slot, int p0, int p1, int p2, int p3, string req);
    logic [31:0] exp;
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
    rdAddr = {1'(half), SLOT_W'(slot)};
    @(posedge clk); #1;
    exp = {sampleOf(p3, half*4+3, slot), sampleOf(p2, half*4+2, slot),
           sampleOf(p1, half*4+1, slot), sampleOf(p0, half*4+0, slot)};
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset halfReady", {31'b0, halfReady}, 32'd0);
    check("R1 reset frameErr", {31'b0, frameErr}, 32'd0);
    check("R1 reset rdData", rdData, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R2: junk before any sync is ignored
    for (int i = 0; i < 29; i++) sendBit(1'(i % 3), 1'b0, 1'b0, 1'b0);

    // R3, R4, R5: first ring, sync only at the start, gaps in half 1 (R10)
    for (int f = 0; f < 8; f++) sendFrame(0, f, f == 0, f >= 4);
    check("R2 first sync no error", {31'b0, frameErr}, 32'd0);
    for (int h = 0; h < 2; h++)
      for (int s = 0; s < SLOTS; s++) readRow(h, s, 0, 0, 0, 0, "R4 lane mapping");

    // R6, R7: wrap into half 0 with a boundary sync
    for (int f = 0; f < 4; f++) sendFrame(1, f, f == 0, 1'b0);
    check("R7 boundary sync no error", {31'b0, frameErr}, 32'd0);
    for (int s = 0; s < SLOTS; s++) readRow(0, s, 1, 1, 1, 1, "R6 half 0 overwritten");
    for (int s = 0; s < SLOTS; s++) readRow(1, s, 0, 0, 0, 0, "R6 half 1 preserved");

    // R8: early sync part way into ring frame 4
    for (int i = 0; i < 26; i++) sendBit(1'(i % 2), 1'b0, 1'b0, 1'b0);
    check("R8 no error before early sync", {31'b0, frameErr}, 32'd0);
    sendFrame(2, 4, 1'b1, 1'b0);
    check("R8 early sync sets error", {31'b0, frameErr}, 32'd1);
    for (int f = 5; f < 8; f++) sendFrame(2, f, 1'b0, 1'b0);
    check("R8 error sticky", {31'b0, frameErr}, 32'd1);
    for (int s = 0; s < SLOTS; s++) readRow(1, s, 2, 2, 2, 2, "R8 realigned frame");

    // R9: address change shows new row after one edge
    readRow(0, 5, 1, 1, 1, 1, "R9 read latency");
    readRow(1, 2, 2, 2, 2, 2, "R9 read latency");

    // R1: reset clears sticky error
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears frameErr", {31'b0, frameErr}, 32'd0);
    check("R1 reset clears rdData", rdData, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule